// File: doc/BRIEF.md
# Load/Store Address Generator

This block computes the effective address of one memory access and, where the addressing mode requires it, the new value for a base register. A decode stage presents a mode code, the register operands (base, index, modifier, global pointer), an immediate field, a pre-extended 32-bit immediate, a 2-bit index shift and an access-size code. The block returns the effective address, a writeback value and a writeback-enable flag. It does not touch memory, and it does not implement bit-reversed or circular addressing.

Offsets taken from the immediate field are scaled to the access size. A size code of 0, 1, 2 or 3 means byte, half, word or double, and the offset is shifted left by that code. The two post-increment modes address memory with the base register as it stands and return the advanced base on the writeback path. All sums wrap modulo 2^32.

The address logic is combinational. A parameter selects either one output register stage (the default) or a direct combinational path. The asynchronous active-low reset goes through a two-flop synchronizer before it clears the output stage.

Top module: `lsu_agu`

## Requirements
- R1: Mode 0 (base plus offset): address = base + (sign-extended imm[10:0] << size). Writeback enable is 0.
- R2: Mode 1 (register plus register): address = base + (index << shamt). Writeback enable is 0.
- R3: Mode 2 (scaled index plus immediate): address = (index << shamt) + ext_imm. Writeback enable is 0.
- R4: Mode 3 (absolute with capture): address = ext_imm, writeback value = ext_imm, writeback enable = 1.
- R5: Mode 4 (post-increment by immediate): address = base, writeback value = base + (sign-extended imm[3:0] << size), writeback enable = 1.
- R6: Mode 5 (post-increment by modifier): address = base, writeback value = base + modifier, writeback enable = 1.
- R7: Mode 6 (global-pointer relative): address = gp + (zero-extended imm[15:0] << size). Writeback enable is 0.
- R8: Every address and writeback sum wraps modulo 2^32.
- R9: Mode 7 is reserved. It drives address 0, writeback value 0 and writeback enable 0.
- R10: Whenever writeback enable is 0, the writeback value is 0.
- R11: With the default registered stage, outputs show the result for the inputs present at the previous rising clock edge. While reset is held, and for two edges after it is released, all outputs are 0.
- R12: Immediate bits above the field a mode uses have no effect on its outputs. This covers imm[15:11] in mode 0 and imm[15:4] in mode 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Addressing mode code (0..7) |
| size_i | input | 2 | Access size code: 0 byte, 1 half, 2 word, 3 double |
| base_i | input | 32 | Base register value |
| index_i | input | 32 | Index register value |
| modreg_i | input | 32 | Modifier register value |
| gp_i | input | 32 | Global pointer value |
| imm_i | input | 16 | Raw immediate field |
| shamt_i | input | 2 | Index shift amount |
| ext_imm_i | input | 32 | Pre-extended 6-bit immediate |
| ea_o | output | 32 | Effective address |
| wb_val_o | output | 32 | Base-register writeback value |
| wb_en_o | output | 1 | Writeback enable |

## Verification
The hardest cases to reach are sums that wrap past 2^32 together with the largest scaled negative offsets, for example a 4-bit post-increment of -8 at double size, which gives -64. Uniform random operands almost never land there. Directed vectors therefore place the base near 0xFFFF_FFFF and near 0, and set the immediate sign bits at every size code. Further vectors fill the unused high immediate bits with ones, to show those bits do not leak into the result. Random vectors cover every mode, with the high immediate bits left random.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int AGU_AW = 32;

  typedef enum logic [2:0] {
    AM_BASE_OFS = 3'd0,
    AM_REG_REG  = 3'd1,
    AM_IDX_IMM  = 3'd2,
    AM_ABS_CAP  = 3'd3,
    AM_POST_IMM = 3'd4,
    AM_POST_MOD = 3'd5,
    AM_GP_REL   = 3'd6,
    AM_RSVD     = 3'd7
  } agu_mode_e;

  typedef struct packed {
    logic [AGU_AW-1:0] addr;
    logic [AGU_AW-1:0] wb_val;
    logic              wb_en;
  } agu_result_t;
endpackage

// File: rtl/agu_offset_gen.sv
module agu_offset_gen #(
  parameter int AW     = 32,
  parameter int IMM_W  = 16,
  parameter int OFS_W  = 11,
  parameter int PINC_W = 4,
  parameter int GP_W   = 16
) (
  input  logic [IMM_W-1:0] imm_i,
  input  logic [1:0]       size_i,
  output logic [AW-1:0]    ofs_o,
  output logic [AW-1:0]    pinc_o,
  output logic [AW-1:0]    gpofs_o
);
  localparam int OFS_PAD  = AW - OFS_W;
  localparam int PINC_PAD = AW - PINC_W;
  localparam int GP_PAD   = AW - GP_W;

  logic [AW-1:0] ofs_ext, pinc_ext, gp_ext;

  always_comb begin
    ofs_ext  = {{OFS_PAD{imm_i[OFS_W-1]}}, imm_i[OFS_W-1:0]};
    pinc_ext = {{PINC_PAD{imm_i[PINC_W-1]}}, imm_i[PINC_W-1:0]};
    gp_ext   = {{GP_PAD{1'b0}}, imm_i[GP_W-1:0]};
    ofs_o    = ofs_ext << size_i;
    pinc_o   = pinc_ext << size_i;
    gpofs_o  = gp_ext << size_i;
  end
endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
  import agu_pkg::*;
(
  input  agu_mode_e          mode_i,
  input  logic [AGU_AW-1:0]  base_i,
  input  logic [AGU_AW-1:0]  index_i,
  input  logic [AGU_AW-1:0]  modreg_i,
  input  logic [AGU_AW-1:0]  gp_i,
  input  logic [1:0]         shamt_i,
  input  logic [AGU_AW-1:0]  ext_imm_i,
  input  logic [AGU_AW-1:0]  ofs_i,
  input  logic [AGU_AW-1:0]  pinc_i,
  input  logic [AGU_AW-1:0]  gpofs_i,
  output agu_result_t        res_o
);
  logic [AGU_AW-1:0] idx_sh;

  always_comb begin
    idx_sh = index_i << shamt_i;
    res_o  = '0;
    unique case (mode_i)
      AM_BASE_OFS: res_o.addr = base_i + ofs_i;
      AM_REG_REG:  res_o.addr = base_i + idx_sh;
      AM_IDX_IMM:  res_o.addr = idx_sh + ext_imm_i;
      AM_ABS_CAP: begin
        res_o.addr   = ext_imm_i;
        res_o.wb_val = ext_imm_i;
        res_o.wb_en  = 1'b1;
      end
      AM_POST_IMM: begin
        res_o.addr   = base_i;
        res_o.wb_val = base_i + pinc_i;
        res_o.wb_en  = 1'b1;
      end
      AM_POST_MOD: begin
        res_o.addr   = base_i;
        res_o.wb_val = base_i + modreg_i;
        res_o.wb_en  = 1'b1;
      end
      AM_GP_REL:   res_o.addr = gp_i + gpofs_i;
      default:     res_o = '0;
    endcase
  end
endmodule

// File: rtl/agu_out_stage.sv
module agu_out_stage
  import agu_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  agu_result_t d_i,
  output agu_result_t q_o
);
  generate
    if (REG_OUT) begin : g_reg
      agu_result_t q_r, q_nxt;

      always_comb begin
        q_nxt = d_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= q_nxt;
      end

      assign q_o = q_r;
    end else begin : g_comb
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/lsu_agu.sv
module lsu_agu
  import agu_pkg::*;
#(
  parameter int IMM_W   = 16,
  parameter int OFS_W   = 11,
  parameter int PINC_W  = 4,
  parameter int GP_W    = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_i,
  input  logic [1:0]        size_i,
  input  logic [AGU_AW-1:0] base_i,
  input  logic [AGU_AW-1:0] index_i,
  input  logic [AGU_AW-1:0] modreg_i,
  input  logic [AGU_AW-1:0] gp_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [1:0]        shamt_i,
  input  logic [AGU_AW-1:0] ext_imm_i,
  output logic [AGU_AW-1:0] ea_o,
  output logic [AGU_AW-1:0] wb_val_o,
  output logic              wb_en_o
);
  logic [1:0]        rst_sync;
  logic              rst_q_n;
  logic [AGU_AW-1:0] ofs, pinc, gpofs;
  agu_result_t       res_d, res_q;

  // reset: asserted asynchronously, released on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  agu_offset_gen #(
    .AW(AGU_AW), .IMM_W(IMM_W), .OFS_W(OFS_W), .PINC_W(PINC_W), .GP_W(GP_W)
  ) u_ofs (
    .imm_i(imm_i), .size_i(size_i),
    .ofs_o(ofs), .pinc_o(pinc), .gpofs_o(gpofs)
  );

  agu_addr_calc u_calc (
    .mode_i(agu_mode_e'(mode_i)), .base_i(base_i), .index_i(index_i),
    .modreg_i(modreg_i), .gp_i(gp_i), .shamt_i(shamt_i),
    .ext_imm_i(ext_imm_i), .ofs_i(ofs), .pinc_i(pinc), .gpofs_i(gpofs),
    .res_o(res_d)
  );

  agu_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst_n(rst_q_n), .d_i(res_d), .q_o(res_q)
  );

  assign ea_o     = res_q.addr;
  assign wb_val_o = res_q.wb_val;
  assign wb_en_o  = res_q.wb_en;
endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rst_q_n,
  input logic [2:0]  mode,
  input logic [31:0] base,
  input logic [31:0] modreg,
  input logic [31:0] ext_imm,
  input logic [31:0] ea,
  input logic [31:0] wb_val,
  input logic        wb_en
);
  generate
    if (REG_OUT) begin : g_seq
      logic primed;
      always_ff @(posedge clk or negedge rst_q_n) begin
        if (!rst_q_n) primed <= 1'b0;
        else          primed <= 1'b1;
      end

      // R4
      abs_cap_chk: assert property (@(posedge clk) disable iff (!primed)
        $past(mode) == 3'd3 |-> (ea == $past(ext_imm) && wb_val == $past(ext_imm) && wb_en));
      // R5
      post_imm_addr_chk: assert property (@(posedge clk) disable iff (!primed)
        $past(mode) == 3'd4 |-> (ea == $past(base) && wb_en));
      // R6
      post_mod_chk: assert property (@(posedge clk) disable iff (!primed)
        $past(mode) == 3'd5 |-> (ea == $past(base) && wb_val == $past(base) + $past(modreg) && wb_en));
      // R9
      rsvd_zero_chk: assert property (@(posedge clk) disable iff (!primed)
        $past(mode) == 3'd7 |-> (ea == 32'd0 && !wb_en));
      // R1
      no_wb_chk: assert property (@(posedge clk) disable iff (!primed)
        ($past(mode) == 3'd0 || $past(mode) == 3'd1 || $past(mode) == 3'd2 || $past(mode) == 3'd6)
        |-> !wb_en);
      // R10
      wb_quiet_chk: assert property (@(posedge clk) disable iff (!primed)
        !wb_en |-> wb_val == 32'd0);
    end else begin : g_comb
      // R4
      abs_cap_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
        mode == 3'd3 |-> (ea == ext_imm && wb_val == ext_imm && wb_en));
      // R5
      post_imm_addr_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
        mode == 3'd4 |-> (ea == base && wb_en));
      // R6
      post_mod_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
        mode == 3'd5 |-> (ea == base && wb_val == base + modreg && wb_en));
      // R10
      wb_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
        !wb_en |-> wb_val == 32'd0);
    end
  endgenerate
endmodule

bind lsu_agu agu_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .mode(mode_i), .base(base_i),
  .modreg(modreg_i), .ext_imm(ext_imm_i), .ea(ea_o),
  .wb_val(wb_val_o), .wb_en(wb_en_o)
);

// File: tb/lsu_agu_tb.sv
`timescale 1ns/1ps
module lsu_agu_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  mode;
  logic [1:0]  size, shamt;
  logic [31:0] base, index, modreg, gp, ext_imm;
  logic [15:0] imm;
  logic [31:0] ea, wb_val;
  logic        wb_en;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  lsu_agu u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .size_i(size), .base_i(base),
    .index_i(index), .modreg_i(modreg), .gp_i(gp), .imm_i(imm),
    .shamt_i(shamt), .ext_imm_i(ext_imm), .ea_o(ea), .wb_val_o(wb_val),
    .wb_en_o(wb_en)
  );

  // reference: {wb_en, wb_val, addr}
  function automatic logic [64:0] model(
    input logic [2:0] m, input logic [1:0] sz, input logic [31:0] b,
    input logic [31:0] ix, input logic [31:0] mr, input logic [31:0] g,
    input logic [15:0] im, input logic [1:0] sh, input logic [31:0] xi);
    logic [31:0] scale, a, w, o11, o4;
    logic        e;
    scale = 32'd1 << sz;
    o11 = im[10] ? (32'hFFFF_F800 | {21'd0, im[10:0]}) : {21'd0, im[10:0]};
    o4  = im[3]  ? (32'hFFFF_FFF0 | {28'd0, im[3:0]})  : {28'd0, im[3:0]};
    a = 0; w = 0; e = 0;
    case (m)
      3'd0: a = b + o11 * scale;
      3'd1: a = b + ix * (32'd1 << sh);
      3'd2: a = ix * (32'd1 << sh) + xi;
      3'd3: begin a = xi; w = xi; e = 1; end
      3'd4: begin a = b; w = b + o4 * scale; e = 1; end
      3'd5: begin a = b; w = b + mr; e = 1; end
      3'd6: a = g + {16'd0, im} * scale;
      default: ;
    endcase
    return {e, w, a};
  endfunction

  task automatic drive(input logic [2:0] m, input logic [1:0] sz, input logic [31:0] b,
                       input logic [31:0] ix, input logic [31:0] mr, input logic [31:0] g,
                       input logic [15:0] im, input logic [1:0] sh, input logic [31:0] xi);
    mode = m; size = sz; base = b; index = ix; modreg = mr; gp = g;
    imm = im; shamt = sh; ext_imm = xi;
  endtask

  task automatic check(input string req, input logic [64:0] exp);
    n_chk++;
    if ({wb_en, wb_val, ea} !== exp) begin
      n_fail++;
      $display("FAIL %s: got en=%0b wb=%h ea=%h exp en=%0b wb=%h ea=%h",
               req, wb_en, wb_val, ea, exp[64], exp[63:32], exp[31:0]);
    end
  endtask

  // drive at negedge, result appears after the next posedge, sample at negedge
  task automatic run(input string req, input logic [2:0] m, input logic [1:0] sz,
                     input logic [31:0] b, input logic [31:0] ix, input logic [31:0] mr,
                     input logic [31:0] g, input logic [15:0] im, input logic [1:0] sh,
                     input logic [31:0] xi);
    drive(m, sz, b, ix, mr, g, im, sh, xi);
    @(posedge clk);
    @(negedge clk);
    check(req, model(m, sz, b, ix, mr, g, im, sh, xi));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    drive(3'd6, 2'd3, 32'h1111_0000, 32'h5, 32'h7, 32'hABCD_0000, 16'h0123, 2'd1, 32'h33);
    repeat (4) @(negedge clk);
    // R11: outputs held at zero during reset despite active inputs
    check("R11 reset", 65'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 sync release", 65'd0);
    repeat (3) @(negedge clk);
    check("R11 post-release", model(3'd6, 2'd3, 32'h1111_0000, 32'h5, 32'h7,
                                    32'hABCD_0000, 16'h0123, 2'd1, 32'h33));

    // R11: new inputs not visible before the edge
    drive(3'd3, 2'd0, 0, 0, 0, 0, 0, 0, 32'h0000_002A);
    #1 check("R11 latency", model(3'd6, 2'd3, 32'h1111_0000, 32'h5, 32'h7,
                                  32'hABCD_0000, 16'h0123, 2'd1, 32'h33));
    @(posedge clk); @(negedge clk);
    check("R4 abs", model(3'd3, 2'd0, 0, 0, 0, 0, 0, 0, 32'h2A));

    // directed corners
    run("R1 neg ofs dbl", 3'd0, 2'd3, 32'h0000_1000, 0, 0, 0, 16'h0400, 0, 0);
    run("R1 R8 wrap", 3'd0, 2'd2, 32'hFFFF_FFF0, 0, 0, 0, 16'h03FF, 0, 0);
    run("R12 mode0 high bits", 3'd0, 2'd1, 32'h100, 0, 0, 0, 16'hF805, 0, 0);
    run("R2 regreg", 3'd1, 2'd0, 32'h8000_0000, 32'hC000_0001, 0, 0, 0, 2'd3, 0);
    run("R3 idximm", 3'd2, 2'd0, 0, 32'h4000_0003, 0, 0, 0, 2'd2, 32'h0000_003F);
    run("R5 pinc -8 dbl", 3'd4, 2'd3, 32'h0000_0020, 0, 0, 0, 16'h0008, 0, 0);
    run("R12 mode4 high bits", 3'd4, 2'd2, 32'h40, 0, 0, 0, 16'hFFF7, 0, 0);
    run("R5 R8 wrap", 3'd4, 2'd3, 32'hFFFF_FFFC, 0, 0, 0, 16'h0007, 0, 0);
    run("R6 R8 postmod wrap", 3'd5, 2'd0, 32'hFFFF_FF00, 0, 32'h0000_0200, 0, 0, 0, 0);
    run("R7 gp max", 3'd6, 2'd3, 0, 0, 0, 32'hFFF0_0000, 16'hFFFF, 0, 0);
    run("R9 rsvd", 3'd7, 2'd3, 32'hDEAD_BEEF, 32'h1, 32'h2, 32'h3, 16'hFFFF, 2'd3, 32'h3F);
    run("R10 no wb", 3'd1, 2'd2, 32'h1234_5678, 32'h11, 32'hFFFF_FFFF, 0, 16'hFFFF, 2'd1, 0);

    for (int i = 0; i < 400; i++) begin
      logic [2:0] m;
      m = 3'($urandom_range(0, 7));
      run($sformatf("R%0d random", (m == 3'd7) ? 9 : int'(m) + 1 + (m >= 3'd6 ? 0 : 0)),
          m, 2'($urandom), $urandom, $urandom, $urandom, $urandom,
          16'($urandom), 2'($urandom), $urandom);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule